// File: doc/BRIEF.md
# Boot Sector Map and Protection Unit

This block sits between the command logic of a flash array and its program and erase engine. It takes the address presented on the pins and works out which of 19 sectors is addressed. The sector sizes are not uniform: the small boot sectors sit at the low end of the space for the bottom-boot layout and at the high end for the top-boot layout, and the two maps mirror each other. In byte mode the address gains one extra least significant bit, which is taken from the top data pin. The sector is always decided by the word-sized part of the address.

The block holds one lock bit per sector. Every single-sector program or erase request is checked against these bits, and so is every multi-sector erase request. An allowed request gets a one-cycle grant that carries the mask of sectors the engine may touch. A request that is not allowed gets a one-cycle fault instead. Lock and unlock commands change the bits. Unlocking is allowed only while every sector is locked.

A temporary-unlock input lifts all protection while it is high. It leaves the stored bits alone, so the earlier protection returns as soon as the input falls. A verify-read port reports whether the addressed sector is locked, using a fixed one-byte code. The high-voltage signalling that selects these modes on a real device is replaced here by plain logic inputs.

Top module: `sector_guard`

## Requirements
- R1: While rst_n is low at a clock edge, all lock bits clear. After that edge, op_grant, op_fault, grant_mask, cmd_fault, vrd_valid, vrd_data and vrd_hi_oe are all zero.
- R2: With boot_top=0, the word address maps to sectors as follows. Sector 0 is 0x00000-0x01FFF, sector 1 is 0x02000-0x02FFF and sector 2 is 0x03000-0x03FFF. Sector 3 is 0x04000-0x07FFF. Sectors 4 to 18 are 32K-word blocks from 0x08000 upward, in address order.
- R3: With boot_top=1, the map is mirrored. Sectors 0 to 14 are 32K-word blocks from 0x00000. Sector 15 is 0x78000-0x7BFFF, sectors 16 and 17 are 4K words each from 0x7C000, and sector 18 is 0x7E000-0x7FFFF.
- R4: With byte_mode=1, the byte address is {addr_pins, dq15_pin}, and the sector map uses byte sizes that are double the word sizes. As a result, dq15_pin never changes the selected sector. With byte_mode=0, dq15_pin is ignored.
- R5: A lock_cmd pulse sets the lock bit of the addressed sector. If lock_cmd and unlock_cmd are high together, the lock wins.
- R6: An unlock_cmd pulse clears the addressed sector's bit only if all 19 bits are set. Otherwise no bit changes, and cmd_fault is high for one cycle after the edge.
- R7: A request with op_req=1 and op_multi=0 results, one cycle later, in one of two outcomes. If the addressed sector is unlocked, op_grant=1 and grant_mask has only that sector's bit set. If it is locked, op_fault=1, op_grant=0 and grant_mask=0.
- R8: A request with op_req=1 and op_multi=1 is handled as follows. grant_mask becomes op_mask with the locked sectors removed, and op_grant=1. If nothing remains, op_fault=1 and grant_mask=0.
- R9: While tmp_unlock=1, no sector counts as locked for R7 and R8. When it falls, the stored bits apply again, unchanged.
- R10: A verify read is a vrd_req pulse with addr_pins[6]=0, addr_pins[1]=1 and addr_pins[0]=0. One cycle later it gives vrd_valid=1 and vrd_data[7:0]=0x01 if the stored bit is set, or 0x00 if it is clear. vrd_data[15:8]=0, and vrd_hi_oe=!byte_mode. Any other pattern gives vrd_valid=0 with zero data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_pins | input | 19 | Address pins, most significant bit first |
| dq15_pin | input | 1 | Top data pin, used as the extra low address bit in byte mode |
| byte_mode | input | 1 | 1 selects byte addressing |
| boot_top | input | 1 | 1 selects the top-boot layout |
| tmp_unlock | input | 1 | Lifts all protection while high |
| lock_cmd | input | 1 | Lock the addressed sector |
| unlock_cmd | input | 1 | Unlock the addressed sector |
| op_req | input | 1 | Program or erase request |
| op_multi | input | 1 | 1 means the request uses op_mask instead of the address |
| op_mask | input | 19 | Sector mask for a multi-sector erase |
| vrd_req | input | 1 | Protection verify read |
| op_grant | output | 1 | Request granted, one cycle |
| op_fault | output | 1 | Request rejected, one cycle |
| grant_mask | output | 19 | Sectors the engine may act on |
| cmd_fault | output | 1 | Unlock refused |
| vrd_valid | output | 1 | Verify data valid |
| vrd_data | output | 16 | Verify code |
| vrd_hi_oe | output | 1 | Drive enable for the upper data byte |

## Verification
A wrong boundary in either layout, or a wrong mirror, shows up one cycle after a single-sector request: grant_mask carries the wrong sector bit. Probing the first and last address of every sector in both layouts and both address modes catches this at once. A corrupted or stale lock bit stays hidden until that sector is requested or verify-read, so every such access is compared on the cycle after its request. Long random runs that mix the command inputs give each bit many chances to show a mismatch. The temporary unlock cannot drop bits without notice, because the cycle after it falls must fault again on every sector that was locked before.

// File: rtl/sector_guard_pkg.sv
// sector_guard_pkg: shared command type and verify-read constants.
// Assumes: the verify address pattern and codes are fixed by the bus protocol.
package sector_guard_pkg;
    typedef enum logic [1:0] {
        LCMD_NONE   = 2'd0,
        LCMD_LOCK   = 2'd1,
        LCMD_UNLOCK = 2'd2
    } lock_cmd_e;

    localparam int VRD_BIT_LOW  = 6;  // must be 0
    localparam int VRD_BIT_HIGH = 1;  // must be 1
    localparam int VRD_BIT_ZERO = 0;  // must be 0
    localparam logic [7:0] CODE_LOCKED = 8'h01;
    localparam logic [7:0] CODE_OPEN   = 8'h00;
endpackage

// File: rtl/sect_decode.sv
// sect_decode: turns a linear address into a sector index.
// The map has four small boot sectors (2, 1, 1 and 4 units of 4K words)
// and then 32K-word blocks. The top layout is the bottom layout mirrored:
// invert the address, decode, then reverse the index.
// Assumes: lin_addr is a byte address in byte mode and a word address (bit ADDR_W clear) otherwise.
module sect_decode #(
    parameter int ADDR_W   = 19,
    localparam int BIG_SH  = ADDR_W - 4,
    localparam int NUM_SECT = (1 << (ADDR_W - BIG_SH)) + 3,
    localparam int IDX_W   = $clog2(NUM_SECT)
) (
    input  logic [ADDR_W:0]    lin_addr,
    input  logic               byte_mode,
    input  logic               boot_top,
    output logic [IDX_W-1:0]   sect_idx
);
    logic [ADDR_W-1:0] word_a;
    logic [ADDR_W-1:0] mir_a;
    logic [3:0]        big;
    logic [IDX_W-1:0]  bot_idx;

    // Drop the byte-select bit, then mirror for the top layout.
    always_comb begin
        word_a = byte_mode ? lin_addr[ADDR_W:1] : lin_addr[ADDR_W-1:0];
        mir_a  = boot_top ? ~word_a : word_a;
        big    = mir_a[ADDR_W-1:BIG_SH];
    end

    // Decode against the bottom layout, then reverse the index for the top layout.
    always_comb begin
        if (big != 4'd0)
            bot_idx = IDX_W'(big) + IDX_W'(3);
        else if (mir_a[BIG_SH-1])
            bot_idx = IDX_W'(3);
        else if (mir_a[BIG_SH-2])
            bot_idx = mir_a[BIG_SH-3] ? IDX_W'(2) : IDX_W'(1);
        else
            bot_idx = IDX_W'(0);
        sect_idx = boot_top ? (IDX_W'(NUM_SECT - 1) - bot_idx) : bot_idx;
    end
endmodule

// File: rtl/lock_bank.sv
// lock_bank: one lock bit per sector, with lock and unlock commands.
// An unlock is taken only when every bit is set. Otherwise it is refused and flagged.
// Assumes: sect_idx is always below NUM_SECT.
module lock_bank
    import sector_guard_pkg::*;
#(
    parameter int NUM_SECT = 19,
    parameter int IDX_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  lock_cmd_e           cmd,
    input  logic [IDX_W-1:0]    sect_idx,
    output logic [NUM_SECT-1:0] lock_q,
    output logic                cmd_fault
);
    // Apply one command per cycle and report a refused unlock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q    <= '0;
            cmd_fault <= 1'b0;
        end else begin
            cmd_fault <= 1'b0;
            case (cmd)
                LCMD_LOCK:   lock_q[sect_idx] <= 1'b1;
                LCMD_UNLOCK: begin
                    if (&lock_q) lock_q[sect_idx] <= 1'b0;
                    else         cmd_fault        <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    AST_UNLOCK_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (|(~lock_q & $past(lock_q)))) |-> (&$past(lock_q))); // R6
    AST_REFUSE_KEEPS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_fault |-> (lock_q == $past(lock_q))); // R6
endmodule

// File: rtl/access_gate.sv
// access_gate: checks program and erase requests against the lock bits in force.
// A single request is checked for its own sector. A mask request loses its locked
// sectors and faults only when nothing is left. The result is registered for one cycle.
// Assumes: eff_lock already includes the temporary-unlock override.
module access_gate #(
    parameter int NUM_SECT = 19,
    parameter int IDX_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_req,
    input  logic                op_multi,
    input  logic [NUM_SECT-1:0] op_mask,
    input  logic [IDX_W-1:0]    sect_idx,
    input  logic [NUM_SECT-1:0] eff_lock,
    output logic                op_grant,
    output logic                op_fault,
    output logic [NUM_SECT-1:0] grant_mask
);
    logic [NUM_SECT-1:0] want;
    logic [NUM_SECT-1:0] keep;

    // Build the wanted sector set and remove the locked ones.
    always_comb begin
        want = op_multi ? op_mask : (NUM_SECT'(1) << sect_idx);
        keep = want & ~eff_lock;
    end

    // Register the grant or the fault for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_grant   <= 1'b0;
            op_fault   <= 1'b0;
            grant_mask <= '0;
        end else begin
            op_grant   <= op_req && (keep != '0);
            op_fault   <= op_req && (keep == '0);
            grant_mask <= (op_req && (keep != '0)) ? keep : '0;
        end
    end

    AST_GRANT_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_grant && op_fault)); // R7
    AST_NO_LOCKED_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        op_grant |-> ((grant_mask & $past(eff_lock)) == '0)); // R8
    AST_SINGLE_ONE_SECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (op_grant && !$past(op_multi)) |-> ($countones(grant_mask) == 1)); // R7
    AST_FAULT_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        op_fault |-> (grant_mask == '0)); // R8
endmodule

// File: rtl/verify_port.sv
// verify_port: answers a protection verify read with a one-byte code.
// The upper byte is driven only in word mode, because in byte mode the top data
// pin carries an address bit.
// Assumes: locked_bit is the stored bit of the addressed sector, without the override.
module verify_port
    import sector_guard_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        vrd_req,
    input  logic        a_low,
    input  logic        a_high,
    input  logic        a_zero,
    input  logic        byte_mode,
    input  logic        locked_bit,
    output logic        vrd_valid,
    output logic [15:0] vrd_data,
    output logic        vrd_hi_oe
);
    logic hit;

    // Match the fixed address pattern of a verify read.
    always_comb hit = vrd_req && !a_low && a_high && !a_zero;

    // Register the code and the upper-byte enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vrd_valid <= 1'b0;
            vrd_data  <= '0;
            vrd_hi_oe <= 1'b0;
        end else begin
            vrd_valid <= hit;
            vrd_data  <= hit ? {8'h00, (locked_bit ? CODE_LOCKED : CODE_OPEN)} : 16'h0000;
            vrd_hi_oe <= hit && !byte_mode;
        end
    end

    AST_VRD_CODE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        vrd_valid |-> (vrd_data[15:1] == 15'd0)); // R10
    AST_BYTE_HI_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (vrd_valid && $past(byte_mode)) |-> !vrd_hi_oe); // R10
endmodule

// File: rtl/sector_guard.sv
// sector_guard: sector map and protection unit.
// Builds the linear address from the pins, decodes the sector, keeps the lock bits,
// gates program and erase requests, and serves verify reads.
// Assumes: one command per cycle. Lock wins over unlock when both are high.
module sector_guard
    import sector_guard_pkg::*;
#(
    parameter int ADDR_W    = 19,
    localparam int BIG_SH   = ADDR_W - 4,
    localparam int NUM_SECT = (1 << (ADDR_W - BIG_SH)) + 3,
    localparam int IDX_W    = $clog2(NUM_SECT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr_pins,
    input  logic                dq15_pin,
    input  logic                byte_mode,
    input  logic                boot_top,
    input  logic                tmp_unlock,
    input  logic                lock_cmd,
    input  logic                unlock_cmd,
    input  logic                op_req,
    input  logic                op_multi,
    input  logic [NUM_SECT-1:0] op_mask,
    input  logic                vrd_req,
    output logic                op_grant,
    output logic                op_fault,
    output logic [NUM_SECT-1:0] grant_mask,
    output logic                cmd_fault,
    output logic                vrd_valid,
    output logic [15:0]         vrd_data,
    output logic                vrd_hi_oe
);
    logic [ADDR_W:0]     lin_addr;
    logic [IDX_W-1:0]    sect_idx;
    logic [NUM_SECT-1:0] lock_q;
    logic [NUM_SECT-1:0] eff_lock;
    lock_cmd_e           cmd;

    // Form the linear address and pick the command, with lock taking priority.
    always_comb begin
        lin_addr = byte_mode ? {addr_pins, dq15_pin} : {1'b0, addr_pins};
        if (lock_cmd)        cmd = LCMD_LOCK;
        else if (unlock_cmd) cmd = LCMD_UNLOCK;
        else                 cmd = LCMD_NONE;
        eff_lock = tmp_unlock ? '0 : lock_q;
    end

    sect_decode #(.ADDR_W(ADDR_W)) u_decode (
        .lin_addr (lin_addr),
        .byte_mode(byte_mode),
        .boot_top (boot_top),
        .sect_idx (sect_idx)
    );

    lock_bank #(.NUM_SECT(NUM_SECT), .IDX_W(IDX_W)) u_locks (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .sect_idx (sect_idx),
        .lock_q   (lock_q),
        .cmd_fault(cmd_fault)
    );

    access_gate #(.NUM_SECT(NUM_SECT), .IDX_W(IDX_W)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_req    (op_req),
        .op_multi  (op_multi),
        .op_mask   (op_mask),
        .sect_idx  (sect_idx),
        .eff_lock  (eff_lock),
        .op_grant  (op_grant),
        .op_fault  (op_fault),
        .grant_mask(grant_mask)
    );

    verify_port u_verify (
        .clk       (clk),
        .rst_n     (rst_n),
        .vrd_req   (vrd_req),
        .a_low     (addr_pins[VRD_BIT_LOW]),
        .a_high    (addr_pins[VRD_BIT_HIGH]),
        .a_zero    (addr_pins[VRD_BIT_ZERO]),
        .byte_mode (byte_mode),
        .locked_bit(lock_q[sect_idx]),
        .vrd_valid (vrd_valid),
        .vrd_data  (vrd_data),
        .vrd_hi_oe (vrd_hi_oe)
    );

    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        sect_idx < IDX_W'(NUM_SECT)); // R2
    AST_OVERRIDE_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_req && !op_multi && tmp_unlock) |=> op_grant); // R9
    AST_LOCK_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_cmd && $past(rst_n)) |=> lock_q[$past(sect_idx)]); // R5
endmodule

// File: tb/sector_guard_tb.sv
`timescale 1ns/1ps
module sector_guard_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [18:0] addr;
    logic        dq15, byte_m, top, tmp, lk, ul, opr, opm, vr;
    logic [18:0] mask;
    logic        op_grant, op_fault, cmd_fault, vrd_valid, vrd_hi_oe;
    logic [18:0] grant_mask;
    logic [15:0] vrd_data;

    int    n_cmp  = 0;
    int    n_bad  = 0;
    bit    done   = 1'b0;
    string cur_req = "R1";
    bit    lockm [19];

    always #2 clk = ~clk;

    sector_guard dut_i (
        .clk(clk), .rst_n(rst_n), .addr_pins(addr), .dq15_pin(dq15),
        .byte_mode(byte_m), .boot_top(top), .tmp_unlock(tmp),
        .lock_cmd(lk), .unlock_cmd(ul), .op_req(opr), .op_multi(opm),
        .op_mask(mask), .vrd_req(vr), .op_grant(op_grant), .op_fault(op_fault),
        .grant_mask(grant_mask), .cmd_fault(cmd_fault), .vrd_valid(vrd_valid),
        .vrd_data(vrd_data), .vrd_hi_oe(vrd_hi_oe)
    );

    // Sector size in 4K-word units, counted from the bottom of the space.
    function automatic int bsz(input int k);
        if (k == 0) return 2;
        if (k < 3)  return 1;
        if (k == 3) return 4;
        return 8;
    endfunction

    function automatic int sz_of(input int i, input bit t);
        return bsz(t ? 18 - i : i);
    endfunction

    // Walk the sector list in the unit size of the current mode.
    function automatic int sect_of(input logic [19:0] lin, input bit bm, input bit t);
        int unit = bm ? 8192 : 4096;
        int lo = 0;
        for (int i = 0; i < 19; i++) begin
            if (int'(lin) < lo + unit * sz_of(i, t)) return i;
            lo += unit * sz_of(i, t);
        end
        return -1;
    endfunction

    function automatic int start_of(input int s, input bit t);
        int lo = 0;
        for (int i = 0; i < s; i++) lo += 4096 * sz_of(i, t);
        return lo;
    endfunction

    task automatic idle();
        lk = 0; ul = 0; opr = 0; opm = 0; vr = 0; mask = '0;
    endtask

    // One clock: predict the outputs, update the model, then compare after the edge.
    task automatic cyc();
        bit eg = 0, ef = 0, ecf = 0, ev = 0, eoe = 0;
        logic [18:0] egm = '0;
        logic [15:0] ed = '0;
        bit bad = 0;
        if (!rst_n) begin
            for (int i = 0; i < 19; i++) lockm[i] = 0;
        end else begin
            logic [19:0] lin = byte_m ? {addr, dq15} : {1'b0, addr};
            int s = sect_of(lin, byte_m, top);
            bit all = 1;
            logic [18:0] keep = '0;
            for (int i = 0; i < 19; i++) begin
                bit eff = tmp ? 1'b0 : lockm[i];
                if (opm ? (mask[i] && !eff) : (i == s && !eff)) keep[i] = 1'b1;
                if (!lockm[i]) all = 0;
            end
            if (opr) begin
                if (keep != 0) begin eg = 1; egm = keep; end
                else ef = 1;
            end
            if (vr && !addr[6] && addr[1] && !addr[0]) begin
                ev = 1; ed = {15'd0, lockm[s]}; eoe = !byte_m;
            end
            if (lk) lockm[s] = 1;
            else if (ul) begin
                if (all) lockm[s] = 0;
                else ecf = 1;
            end
        end
        @(posedge clk);
        #1;
        n_cmp++;
        if (op_grant !== eg) begin bad = 1; $display("FAIL %s op_grant act=%0b exp=%0b", cur_req, op_grant, eg); end
        if (op_fault !== ef) begin bad = 1; $display("FAIL %s op_fault act=%0b exp=%0b", cur_req, op_fault, ef); end
        if (grant_mask !== egm) begin bad = 1; $display("FAIL %s grant_mask act=%h exp=%h", cur_req, grant_mask, egm); end
        if (cmd_fault !== ecf) begin bad = 1; $display("FAIL %s cmd_fault act=%0b exp=%0b", cur_req, cmd_fault, ecf); end
        if (vrd_valid !== ev) begin bad = 1; $display("FAIL %s vrd_valid act=%0b exp=%0b", cur_req, vrd_valid, ev); end
        if (vrd_data !== ed) begin bad = 1; $display("FAIL %s vrd_data act=%h exp=%h", cur_req, vrd_data, ed); end
        if (vrd_hi_oe !== eoe) begin bad = 1; $display("FAIL %s vrd_hi_oe act=%0b exp=%0b", cur_req, vrd_hi_oe, eoe); end
        if (bad) n_bad++;
    endtask

    task automatic single_op(input logic [18:0] a);
        idle(); addr = a; opr = 1; cyc(); idle(); cyc();
    endtask

    task automatic verify(input logic [18:0] a);
        idle(); addr = a | 19'h2; vr = 1; cyc(); idle(); cyc();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        finish_run();
    end

    initial begin
        rst_n = 0; addr = '0; dq15 = 0; byte_m = 0; top = 0; tmp = 0; idle();
        cur_req = "R1";
        repeat (3) cyc();
        rst_n = 1;
        cyc();

        // Both layouts, first and last word of every sector.
        for (int t = 0; t < 2; t++) begin
            top = t[0];
            cur_req = t ? "R3" : "R2";
            for (int s = 0; s < 19; s++) begin
                single_op(19'(start_of(s, top)));
                single_op(19'(start_of(s, top) + 4096 * sz_of(s, top) - 1));
            end
        end

        // Byte mode: the top data pin is the extra low bit and never moves the sector.
        cur_req = "R4";
        byte_m = 1;
        for (int t = 0; t < 2; t++) begin
            top = t[0];
            for (int s = 0; s < 19; s++) begin
                dq15 = 0; single_op(19'(start_of(s, top)));
                dq15 = 1; single_op(19'(start_of(s, top) + 4096 * sz_of(s, top) - 1));
            end
        end
        byte_m = 0; top = 0; dq15 = 0;

        cur_req = "R6";
        idle(); addr = 19'h0; ul = 1; cyc(); idle(); cyc();

        cur_req = "R5";
        foreach (lockm[s]) if (s == 0 || s == 5 || s == 18) begin
            idle(); addr = 19'(start_of(s, 0)); lk = 1; cyc();
        end
        idle(); cyc();
        cur_req = "R7";
        for (int s = 0; s < 19; s++) single_op(19'(start_of(s, 0)));

        cur_req = "R10";
        verify(19'(start_of(5, 0)));
        verify(19'(start_of(6, 0)));
        byte_m = 1; verify(19'(start_of(5, 0))); byte_m = 0;
        idle(); addr = 19'(start_of(5, 0)) | 19'h40 | 19'h2; vr = 1; cyc();
        addr = 19'(start_of(5, 0)) | 19'h3; cyc();
        idle(); cyc();

        cur_req = "R8";
        idle(); opr = 1; opm = 1; mask = 19'h7FFFF; cyc();
        mask = 19'h40021; cyc();
        mask = 19'h0; cyc();
        mask = 19'h00060; cyc();
        idle(); cyc();

        cur_req = "R9";
        tmp = 1;
        single_op(19'(start_of(5, 0)));
        idle(); opr = 1; opm = 1; mask = 19'h40021; cyc();
        tmp = 0;
        idle(); cyc();
        single_op(19'(start_of(5, 0)));
        single_op(19'(start_of(18, 0)));

        cur_req = "R5";
        idle(); addr = 19'(start_of(7, 0)); lk = 1; ul = 1; cyc(); idle(); cyc();
        for (int s = 0; s < 19; s++) begin
            idle(); addr = 19'(start_of(s, 0)); lk = 1; cyc();
        end
        cur_req = "R6";
        idle(); addr = 19'(start_of(9, 0)); ul = 1; cyc();
        addr = 19'(start_of(10, 0)); ul = 1; cyc();
        idle(); cyc();
        verify(19'(start_of(9, 0)));
        verify(19'(start_of(10, 0)));

        cur_req = "R1 R5 R6 R7 R8 R9 R10";
        for (int k = 0; k < 6000; k++) begin
            rst_n  = ($urandom_range(0, 499) != 0);
            addr   = 19'($urandom);
            dq15   = 1'($urandom);
            byte_m = 1'($urandom);
            top    = 1'($urandom);
            tmp    = ($urandom_range(0, 7) == 0);
            lk     = ($urandom_range(0, 3) == 0);
            ul     = ($urandom_range(0, 3) == 0);
            opr    = 1'($urandom);
            opm    = 1'($urandom);
            mask   = 19'($urandom);
            vr     = 1'($urandom);
            if (vr && $urandom_range(0, 1) == 1) addr = (addr & ~19'h43) | 19'h2;
            cyc();
        end
        rst_n = 1; idle(); cyc();
        finish_run();
    end
endmodule